// File: doc/BRIEF.md
# Transmitter Control Register Target over I2C

This block is the I2C target that a transmitter controller exposes to its host. It holds the configuration registers: operating mode, power-amplifier request, encoder setting, debug lamps, power level and synthesizer offset. It also serves a read-only firmware version, a status byte, a transmit-ready flag and a bank of 16-bit telemetry words that arrive on input ports. SCL and SDA are oversampled by the system clock. The block drives SDA only by pulling it low, through `sda_oe_o`.

A host writes by sending the device address, a register pointer and then data bytes. To read, it first sets the pointer with a write, then issues a repeated start and a read. The pointer steps by one after every byte transferred. The power-amplifier output is only active when two conditions hold: the request bit is set, and the mode is not the configuration mode. A failsafe counter, whose length is a parameter, turns the amplifier off once it has run for the full timeout. The register still shows the request set after that. The amplifier stays off until the host clears the request bit.

Top module: `txctl_i2c_regs`

## Requirements
- R1: The block acknowledges only the 7-bit address 0x26. Any other address gets no acknowledge, and the rest of that transaction changes nothing.
- R2: In a write, the first byte after the address is the pointer. Each following byte is stored at the pointer, and the pointer then advances by one.
- R3: A read returns the byte at the pointer left by the previous write. The pointer advances by one after each byte read, so consecutive bytes come from consecutive addresses.
- R4: All command registers read 0x00 after reset. Their fields are:
  - 0x00: bit 7 is the amplifier request, bits 1:0 are the mode (00 config, 01 sync, 10 data, 11 test).
  - 0x01: bits 3:0 are the encoder setting.
  - 0x02: bits 2:0 are the debug lamps.
  - 0x03: bits 1:0 are the power level.
  - 0x04: bits 6:0 are the synthesizer offset.
  - Undefined bits read 0.
- R5: `pa_on_o` is high only while the request bit is 1 and the mode is not 00. With the request set and mode 00, it stays low until the mode changes.
- R6: Writing a byte with bit 0 = 0 to address 0x05 returns every command register to 0x00. Writing a byte with bit 0 = 1 there has no effect. Address 0x05 reads 0x00.
- R7: Address 0x11 reads the BCD version, with the major digit in bits 7:4 and the minor digit in bits 3:0. The default is 0x15.
- R8: Address 0x12 reads `status_i`. Address 0x13 reads `txready_i` in bit 0. Telemetry word k (bits 16k+15:16k of `tlm_i`) reads as its upper byte at 0x14+2k and its lower byte at 0x15+2k.
- R9: After `pa_on_o` has been high for FAILSAFE_CYCLES consecutive clocks, it goes low while register 0x00 still reads bit 7 = 1. It stays low until bit 7 has been written 0 and then set again.
- R10: Unmapped addresses read 0x00. Writes to any address other than 0x00 to 0x05 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 8 | Status byte served at 0x12 |
| txready_i | input | 1 | Transmit-ready flag served at 0x13 bit 0 |
| tlm_i | input | TLM_WORDS*16 | Telemetry words, word k at bits 16k+15:16k |
| mode_o | output | 2 | Operating mode field |
| pa_on_o | output | 1 | Effective power-amplifier enable |
| enc_cfg_o | output | 4 | Encoder setting field |
| dbg_o | output | 3 | Debug lamp field |
| pwr_lvl_o | output | 2 | Power level field |
| synth_off_o | output | 7 | Synthesizer offset field |

## Verification
The hardest state to reach is the one where the failsafe has tripped while the stored request bit stays set. To get there, the bench shortens the timeout through the parameter, enables the amplifier in sync mode and then leaves the bus idle. It then checks four things: the stretch of high cycles on `pa_on_o` is exactly the timeout, a read-back still shows bit 7 set, a mode change alone does not bring the amplifier back, and only a clear followed by a set does. A reference model in the bench checks the outputs on every clock, and every read byte is compared against the model's register map.

// File: rtl/txctl_i2c_regs.sv
module txctl_i2c_regs #(
  parameter logic [6:0]  DEV_ADDR        = 7'h26,
  parameter logic [3:0]  FW_MAJOR        = 4'd1,
  parameter logic [3:0]  FW_MINOR        = 4'd5,
  parameter int          TLM_WORDS       = 11,
  parameter logic [7:0]  TLM_BASE        = 8'h14,
  parameter logic [39:0] FAILSAFE_CYCLES = 40'd45_000_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [7:0]             status_i,
  input  logic                   txready_i,
  input  logic [TLM_WORDS*16-1:0] tlm_i,
  output logic [1:0]             mode_o,
  output logic                   pa_on_o,
  output logic [3:0]             enc_cfg_o,
  output logic [2:0]             dbg_o,
  output logic [1:0]             pwr_lvl_o,
  output logic [6:0]             synth_off_o
);

  localparam int         TW       = $clog2(FAILSAFE_CYCLES + 40'd1);
  localparam logic [7:0] TLM_LAST = TLM_BASE + 8'(2*TLM_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKA, S_WR, S_ACKW, S_RD, S_RACK} st_t;

  logic [2:0] scl_s, sda_s;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, rbyte, rd_data;
  logic       rw, have_ptr, nack;
  logic       r_pa;
  logic [1:0] r_mode;
  logic [3:0] r_enc;
  logic [2:0] r_dbg;
  logic [1:0] r_pwr;
  logic [6:0] r_syn;
  logic [TW-1:0] fs_cnt;
  logic       fs_trip;
  logic [7:0] toff;
  logic [15:0] tword;
  int         widx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire bus_hi   = scl_s[1] & scl_s[2];
  wire start_c  = bus_hi & ~sda_s[1] & sda_s[2];
  wire stop_c   = bus_hi & sda_s[1] & ~sda_s[2];
  wire bit_in   = sda_s[1];

  wire wr_fire  = scl_fall && st == S_WR && cnt == 4'd8 && have_ptr;
  wire soft_rst = wr_fire && ptr == 8'h05 && !sh[0];

  always_comb begin
    rd_data = 8'h00;
    toff    = ptr - TLM_BASE;
    widx    = int'(toff[7:1]);
    tword   = 16'h0000;
    if (ptr >= TLM_BASE && ptr <= TLM_LAST) begin
      tword   = tlm_i[widx*16 +: 16];
      rd_data = toff[0] ? tword[7:0] : tword[15:8];
    end else begin
      case (ptr)
        8'h00:   rd_data = {r_pa, 5'b0, r_mode};
        8'h01:   rd_data = {4'b0, r_enc};
        8'h02:   rd_data = {5'b0, r_dbg};
        8'h03:   rd_data = {6'b0, r_pwr};
        8'h04:   rd_data = {1'b0, r_syn};
        8'h11:   rd_data = {FW_MAJOR, FW_MINOR};
        8'h12:   rd_data = status_i;
        8'h13:   rd_data = {7'b0, txready_i};
        default: rd_data = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0; rbyte <= '0;
      rw <= 1'b0; have_ptr <= 1'b0; nack <= 1'b0; sda_oe_o <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; have_ptr <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe_o <= 1'b0;
    end else begin
      case (st)
        S_ADDR:
          if (scl_rise) begin
            sh <= {sh[6:0], bit_in}; cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              rw <= sh[0]; st <= S_ACKA; sda_oe_o <= 1'b1;
            end else st <= S_IDLE;
          end
        S_ACKA:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              rbyte <= rd_data; sda_oe_o <= ~rd_data[7]; st <= S_RD;
            end else begin
              sda_oe_o <= 1'b0; st <= S_WR;
            end
          end
        S_WR:
          if (scl_rise) begin
            sh <= {sh[6:0], bit_in}; cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            sda_oe_o <= 1'b1; st <= S_ACKW;
            if (!have_ptr) begin ptr <= sh; have_ptr <= 1'b1; end
            else ptr <= ptr + 8'd1;
          end
        S_ACKW:
          if (scl_fall) begin sda_oe_o <= 1'b0; cnt <= '0; st <= S_WR; end
        S_RD:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0; ptr <= ptr + 8'd1; st <= S_RACK;
            end else sda_oe_o <= ~rbyte[3'd7 - cnt[2:0]];
          end
        S_RACK:
          if (scl_rise) nack <= bit_in;
          else if (scl_fall) begin
            cnt <= '0;
            if (nack) st <= S_IDLE;
            else begin rbyte <= rd_data; sda_oe_o <= ~rd_data[7]; st <= S_RD; end
          end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_pa <= 1'b0; r_mode <= '0; r_enc <= '0; r_dbg <= '0; r_pwr <= '0; r_syn <= '0;
    end else if (soft_rst) begin
      r_pa <= 1'b0; r_mode <= '0; r_enc <= '0; r_dbg <= '0; r_pwr <= '0; r_syn <= '0;
    end else if (wr_fire) begin
      case (ptr)
        8'h00: begin r_pa <= sh[7]; r_mode <= sh[1:0]; end
        8'h01: r_enc <= sh[3:0];
        8'h02: r_dbg <= sh[2:0];
        8'h03: r_pwr <= sh[1:0];
        8'h04: r_syn <= sh[6:0];
        default: ;
      endcase
    end

  assign pa_on_o = r_pa && (r_mode != 2'b00) && !fs_trip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_cnt <= '0; fs_trip <= 1'b0;
    end else if (soft_rst) begin
      fs_cnt <= '0; fs_trip <= 1'b0;
    end else begin
      if (!r_pa) fs_trip <= 1'b0;
      else if (pa_on_o && fs_cnt == TW'(FAILSAFE_CYCLES - 40'd1)) fs_trip <= 1'b1;
      fs_cnt <= pa_on_o ? fs_cnt + 1'b1 : '0;
    end

  assign mode_o      = r_mode;
  assign enc_cfg_o   = r_enc;
  assign dbg_o       = r_dbg;
  assign pwr_lvl_o   = r_pwr;
  assign synth_off_o = r_syn;

  assert_ack_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKA) |-> (sh[7:1] == DEV_ADDR));
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_o);
  assert_cfg_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (r_syn != $past(r_syn)) |-> $past(wr_fire));
  assert_pa_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_on_o) |-> $past(wr_fire));
  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!r_pa && r_mode == 2'b00 && r_enc == 4'h0 && r_syn == 7'h00));
  assert_trip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_trip && r_pa) |=> !pa_on_o);
  assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pa_on_o |-> (fs_cnt < TW'(FAILSAFE_CYCLES)));

endmodule

// File: tb/txctl_i2c_regs_tb.sv
module txctl_i2c_regs_tb;
  localparam int HP = 20, LIMIT = 4000, NW = 11;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  logic [7:0] status = 8'h03;
  logic txready = 1'b1;
  logic [NW*16-1:0] tlm;
  logic [1:0] mode; logic pa_on; logic [3:0] enc; logic [2:0] dbg;
  logic [1:0] pwr; logic [6:0] syn;

  txctl_i2c_regs #(.TLM_WORDS(NW), .FAILSAFE_CYCLES(40'(LIMIT))) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .status_i(status), .txready_i(txready), .tlm_i(tlm),
    .mode_o(mode), .pa_on_o(pa_on), .enc_cfg_o(enc), .dbg_o(dbg),
    .pwr_lvl_o(pwr), .synth_off_o(syn));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, run = 0, maxrun = 0;
  bit busy = 1, done = 0, mtrip = 0;
  logic mpa = 0; logic [1:0] mmode = 0; logic [3:0] menc = 0;
  logic [2:0] mdbg = 0; logic [1:0] mpwr = 0; logic [6:0] msyn = 0;
  logic [7:0] rb [8];

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tword_byte(input int a);
    int k = (a - 'h14) / 2;
    logic [15:0] w = 16'hC000 | 16'(k << 8) | 16'(8'h10 + k);
    return ((a - 'h14) % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a >= 'h14 && a <= 'h29) return tword_byte(a);
    case (a)
      'h00: return {mpa, 5'b0, mmode};
      'h01: return {4'b0, menc};
      'h02: return {5'b0, mdbg};
      'h03: return {6'b0, mpwr};
      'h04: return {1'b0, msyn};
      'h11: return 8'h15;
      'h12: return status;
      'h13: return {7'b0, txready};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0: begin mpa = d[7]; mmode = d[1:0]; end
      1: menc = d[3:0];
      2: mdbg = d[2:0];
      3: mpwr = d[1:0];
      4: msyn = d[6:0];
      5: if (!d[0]) begin mpa = 0; mmode = 0; menc = 0; mdbg = 0; mpwr = 0; msyn = 0; end
      default: ;
    endcase
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (pa_on) run++; else run = 0;
    if (run > maxrun) maxrun = run;
    if (run > LIMIT) begin fails++; $display("FAIL R9 actual=%0d expected<=%0d", run, LIMIT); end
    if (!busy) begin
      checks++;
      if ({mode, pa_on, enc, dbg, pwr, syn} !==
          {mmode, mpa && mmode != 2'b00 && !mtrip, menc, mdbg, mpwr, msyn}) begin
        fails++;
        $display("FAIL R5 actual=%h expected=%h", {mode, pa_on, enc, dbg, pwr, syn},
                 {mmode, mpa && mmode != 2'b00 && !mtrip, menc, mdbg, mpwr, msyn});
      end
    end
    if (run == LIMIT) mtrip = 1;
    if (!mpa) mtrip = 0;
  end

  task automatic tick(input int n); repeat (n) @(posedge clk); #1; endtask
  task automatic i2c_bit(input logic b, output logic s);
    sda_m = b; tick(HP/2); scl = 1; tick(HP/2); s = sda_line; tick(HP/2); scl = 0; tick(HP/2);
  endtask
  task automatic i2c_start;
    sda_m = 1; tick(HP/2); scl = 1; tick(HP/2); sda_m = 0; tick(HP/2); scl = 0; tick(HP/2);
  endtask
  task automatic i2c_stop;
    sda_m = 0; tick(HP/2); scl = 1; tick(HP/2); sda_m = 1; tick(HP);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) i2c_bit(b[i], s);
    i2c_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(input logic last, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin i2c_bit(1'b1, s); b = {b[6:0], s}; end
    i2c_bit(last, s);
  endtask

  task automatic reg_write(input logic [7:0] p, input logic [31:0] d, input int n);
    logic ack;
    busy = 1;
    i2c_start;
    send_byte(8'h4C, ack); check("R1", ack, 1);
    send_byte(p, ack);     check("R2", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[31-8*i -: 8], ack); check("R2", ack, 1);
    end
    i2c_stop; tick(4);
    for (int i = 0; i < n; i++) model_write(int'(p) + i, d[31-8*i -: 8]);
    busy = 0;
  endtask

  task automatic reg_read(input logic [7:0] p, input int n);
    logic ack;
    i2c_start;
    send_byte(8'h4C, ack); check("R1", ack, 1);
    send_byte(p, ack);     check("R3", ack, 1);
    i2c_start;
    send_byte(8'h4D, ack); check("R1", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rb[i]);
    i2c_stop; tick(4);
  endtask

  task automatic read_check(input string tag, input logic [7:0] p, input int n);
    reg_read(p, n);
    for (int i = 0; i < n; i++) check(tag, rb[i], exp_rd(int'(p) + i));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run;
  end

  initial begin
    logic ack;
    for (int k = 0; k < NW; k++) tlm[k*16 +: 16] = 16'hC000 | 16'(k << 8) | 16'(8'h10 + k);
    tick(10); rst_n = 1; tick(5);
    check("R4", {mode, pa_on, enc, dbg, pwr, syn, sda_oe}, '0);
    busy = 0;

    reg_write(8'h00, 32'h80000000, 1);
    check("R5", pa_on, 0);
    read_check("R4", 8'h00, 1);
    reg_write(8'h00, 32'h81000000, 1);
    check("R5", pa_on, 1);
    reg_write(8'h00, 32'h01000000, 1);
    check("R5", pa_on, 0);

    reg_write(8'h01, 32'hFA0503FF, 4);
    check("R2", {enc, dbg, pwr, syn}, {4'hA, 3'd5, 2'd3, 7'h7F});
    read_check("R3", 8'h00, 5);

    read_check("R7", 8'h10, 4);
    read_check("R8", 8'h14, 6);
    read_check("R10", 8'h28, 3);

    reg_write(8'h11, 32'h99000000, 1);
    reg_write(8'h14, 32'h12000000, 1);
    reg_read(8'h11, 1); check("R10", rb[0], 8'h15);
    reg_read(8'h14, 1); check("R10", rb[0], tword_byte('h14));

    busy = 1;
    i2c_start; send_byte(8'h50, ack); check("R1", ack, 0);
    send_byte(8'h03, ack); send_byte(8'h00, ack); i2c_stop; tick(4);
    busy = 0;
    check("R1", pwr, 2'd3);

    reg_write(8'h05, 32'h01000000, 1);
    check("R6", {enc, syn}, {4'hA, 7'h7F});
    read_check("R6", 8'h05, 1);
    reg_write(8'h05, 32'hFE000000, 1);
    check("R6", {mode, enc, dbg, pwr, syn}, '0);

    reg_write(8'h00, 32'h81000000, 1);
    tick(LIMIT + 200);
    check("R9", pa_on, 0);
    check("R9", maxrun, LIMIT);
    read_check("R9", 8'h00, 1);
    reg_write(8'h00, 32'h82000000, 1);
    check("R9", pa_on, 0);
    reg_write(8'h00, 32'h02000000, 1);
    reg_write(8'h00, 32'h82000000, 1);
    check("R9", pa_on, 1);
    reg_write(8'h00, 32'h00000000, 1);
    check("R5", pa_on, 0);

    tick(20);
    finish_run;
  end
endmodule